// File: doc/BRIEF.md
# Integrating ADC Conversion Sequencer

This block is the digital controller of a slow monitoring converter of the dual-slope kind. A single pulse on `start` begins a conversion. The block latches a 4-bit channel number and drives it onto an analog multiplexer select. It waits a programmable number of settling cycles, then enables an external integrator to charge from the selected input for a fixed window of 2^RES_W clock cycles. It then switches that integrator to a constant discharge current. It counts clock cycles until an external comparator reports that the capacitor has returned to its starting level, and that count is the conversion result.

The default configuration gives a 12-bit result, a 4096-cycle charge window and sixteen inputs. A full conversion takes at most about 8200 cycles, so a clock near 41 MHz or faster meets a rate of 5k samples per second over a 1 V range. If the comparator never trips, the result saturates at all ones and an overflow flag is raised. The result, channel tag and overflow flag appear together with a one-cycle `done` pulse. They then hold until the next conversion finishes.

Top module: `iadc_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done`, `charge_en`, `discharge_en` and `overflow` are 0 and `result` is 0.
- R2: A `start` seen high at a clock edge while `busy` is low latches `chan_in`. From the next cycle, `busy` is 1 and `mux_sel` equals the latched channel for the whole conversion. A settle phase of exactly SETTLE_CYCLES cycles follows, with both enables low.
- R3: Directly after the settle phase, `charge_en` is high for exactly 2^RES_W consecutive cycles.
- R4: `discharge_en` rises in the cycle right after the last charge cycle. `charge_en` and `discharge_en` are never high in the same cycle.
- R5: Discharge cycles are numbered from 0. The comparator input `comp_empty` is sampled at the end of each discharge cycle. The result is the number k of the first discharge cycle in which it is seen high, so `discharge_en` is high for k+1 cycles.
- R6: If `comp_empty` is still low at the end of discharge cycle 2^RES_W-1, the conversion ends with `result` equal to all ones and `overflow` = 1. Otherwise `overflow` = 0.
- R7: A `start` seen while `busy` is high has no effect. `mux_sel`, the phase lengths and the result of the running conversion do not change.
- R8: `done` is high for exactly one cycle per conversion. `chan_tag` then equals the latched channel. `result`, `chan_tag` and `overflow` do not change between two `done` pulses.
- R9: `busy` falls in the same cycle that `done` rises. A `start` seen during that cycle is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled at clock edges |
| chan_in | input | CH_W | Channel to convert, latched on an accepted start |
| comp_empty | input | 1 | Comparator: high when the capacitor has discharged |
| mux_sel | output | CH_W | Analog multiplexer select |
| charge_en | output | 1 | Enables input-driven charging of the integrator |
| discharge_en | output | 1 | Enables the constant discharge current |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| result | output | RES_W | Discharge cycle count |
| chan_tag | output | CH_W | Channel the result belongs to |
| overflow | output | 1 | Comparator never tripped; result saturated |

## Verification
The hardest situation to reach is the exact boundary between a trip in the very last discharge cycle and saturation. The two give the same all-ones result and differ only in the overflow flag. The bench builds the block with a 6-bit result so that the charge window is 64 cycles. A behavioural comparator trips after a programmed number of discharge cycles, and the bench sweeps that number through every value from 0 to three past the saturation point. It also raises `start` with a different channel in the middle of every conversion, and issues one request in the very cycle of a `done` pulse.

// File: rtl/iadc_pkg.sv
package iadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_CHARGE = 2'd2,
    PH_DISCH  = 2'd3
  } phase_t;
endpackage

// File: rtl/iadc_phase_cnt.sv
module iadc_phase_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/iadc_phase_fsm.sv
module iadc_phase_fsm
  import iadc_pkg::*;
#(
  parameter int CNT_W         = 12,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             comp_empty,
  input  logic [CNT_W-1:0] cnt,
  output phase_t           phase,
  output phase_t           phase_nxt,
  output logic             accept,
  output logic             cnt_clr,
  output logic             finish,
  output logic             sat_hit
);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] WINDOW_LAST = {CNT_W{1'b1}};

  always_comb begin
    phase_nxt = phase;
    accept    = 1'b0;
    cnt_clr   = 1'b0;
    finish    = 1'b0;
    sat_hit   = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        phase_nxt = PH_SETTLE;
        accept    = 1'b1;
        cnt_clr   = 1'b1;
      end
      PH_SETTLE: if (cnt == SETTLE_LAST) begin
        phase_nxt = PH_CHARGE;
        cnt_clr   = 1'b1;
      end
      PH_CHARGE: if (cnt == WINDOW_LAST) begin
        phase_nxt = PH_DISCH;
        cnt_clr   = 1'b1;
      end
      PH_DISCH: begin
        if (comp_empty) begin
          phase_nxt = PH_IDLE;
          finish    = 1'b1;
          cnt_clr   = 1'b1;
        end else if (cnt == WINDOW_LAST) begin
          phase_nxt = PH_IDLE;
          finish    = 1'b1;
          sat_hit   = 1'b1;
          cnt_clr   = 1'b1;
        end
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nxt;
  end
endmodule

// File: rtl/iadc_capture.sv
module iadc_capture #(
  parameter int RES_W = 12,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             finish,
  input  logic             sat_hit,
  input  logic [RES_W-1:0] cnt,
  input  logic [CH_W-1:0]  chan,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  chan_tag,
  output logic             overflow,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      chan_tag <= '0;
      overflow <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        result   <= sat_hit ? {RES_W{1'b1}} : cnt;
        chan_tag <= chan;
        overflow <= sat_hit;
      end
    end
  end
endmodule

// File: rtl/iadc_sequencer.sv
module iadc_sequencer
  import iadc_pkg::*;
#(
  parameter int RES_W         = 12,
  parameter int CH_W          = 4,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CH_W-1:0]  chan_in,
  input  logic             comp_empty,
  output logic [CH_W-1:0]  mux_sel,
  output logic             charge_en,
  output logic             discharge_en,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  chan_tag,
  output logic             overflow
);
  phase_t            phase, phase_nxt;
  logic              accept, cnt_clr, finish, sat_hit;
  logic [RES_W-1:0]  cnt;

  iadc_phase_cnt #(.W(RES_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .en  (phase != PH_IDLE),
    .cnt (cnt)
  );

  iadc_phase_fsm #(.CNT_W(RES_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .comp_empty (comp_empty),
    .cnt        (cnt),
    .phase      (phase),
    .phase_nxt  (phase_nxt),
    .accept     (accept),
    .cnt_clr    (cnt_clr),
    .finish     (finish),
    .sat_hit    (sat_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_sel      <= '0;
      charge_en    <= 1'b0;
      discharge_en <= 1'b0;
      busy         <= 1'b0;
    end else begin
      if (accept) mux_sel <= chan_in;
      charge_en    <= (phase_nxt == PH_CHARGE);
      discharge_en <= (phase_nxt == PH_DISCH);
      busy         <= (phase_nxt != PH_IDLE);
    end
  end

  iadc_capture #(.RES_W(RES_W), .CH_W(CH_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .finish   (finish),
    .sat_hit  (sat_hit),
    .cnt      (cnt),
    .chan     (mux_sel),
    .result   (result),
    .chan_tag (chan_tag),
    .overflow (overflow),
    .done     (done)
  );
endmodule

// File: rtl/iadc_sequencer_chk.sv
module iadc_sequencer_chk #(
  parameter int RES_W         = 12,
  parameter int CH_W          = 4,
  parameter int SETTLE_CYCLES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CH_W-1:0]  mux_sel,
  input logic             charge_en,
  input logic             discharge_en,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result,
  input logic [CH_W-1:0]  chan_tag,
  input logic             overflow
);
  localparam int WINDOW = 1 << RES_W;
  logic [RES_W:0] chg_run;

  always_ff @(posedge clk) begin
    if (rst)            chg_run <= '0;
    else if (charge_en) chg_run <= chg_run + 1'b1;
    else                chg_run <= '0;
  end

  assert_charge_window_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(charge_en) |-> (chg_run == (RES_W+1)'(WINDOW)));

  assert_disch_follows_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(charge_en) |-> discharge_en);

  assert_enables_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(charge_en && discharge_en));

  assert_enables_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (charge_en || discharge_en) |-> busy);

  assert_saturate_R6: assert property (@(posedge clk) disable iff (rst)
    (done && overflow) |-> (result == {RES_W{1'b1}}));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mux_sel));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(chan_tag) && $stable(overflow)));

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy);
endmodule

bind iadc_sequencer iadc_sequencer_chk #(
  .RES_W(RES_W), .CH_W(CH_W), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .mux_sel      (mux_sel),
  .charge_en    (charge_en),
  .discharge_en (discharge_en),
  .busy         (busy),
  .done         (done),
  .result       (result),
  .chan_tag     (chan_tag),
  .overflow     (overflow)
);

// File: tb/iadc_sequencer_bench.sv
`timescale 1ns/1ps
module iadc_sequencer_bench;
  localparam int RES_W  = 6;
  localparam int CH_W   = 4;
  localparam int SETTLE = 3;
  localparam int WINDOW = 1 << RES_W;
  localparam int MAXV   = WINDOW - 1;
  localparam int LIM    = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CH_W-1:0] chan_in = '0;
  logic comp_empty;
  logic [CH_W-1:0] mux_sel, chan_tag;
  logic charge_en, discharge_en, busy, done, overflow;
  logic [RES_W-1:0] result;

  int checks = 0;
  int fails  = 0;
  int target = 0;
  int dcount = 0;
  int set_cnt, chg_cnt, dis_cnt, mux_err;
  int exp_ch = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  iadc_sequencer #(.RES_W(RES_W), .CH_W(CH_W), .SETTLE_CYCLES(SETTLE)) u_iadc_sequencer (
    .clk(clk), .rst(rst), .start(start), .chan_in(chan_in), .comp_empty(comp_empty),
    .mux_sel(mux_sel), .charge_en(charge_en), .discharge_en(discharge_en),
    .busy(busy), .done(done), .result(result), .chan_tag(chan_tag), .overflow(overflow)
  );

  // Behavioural integrator/comparator: empty after 'target' full discharge cycles
  assign comp_empty = discharge_en && (dcount >= target);

  always @(posedge clk) begin
    dcount <= discharge_en ? dcount + 1 : 0;
    if (busy && !charge_en && !discharge_en) set_cnt <= set_cnt + 1;
    if (charge_en)    chg_cnt <= chg_cnt + 1;
    if (discharge_en) dis_cnt <= dis_cnt + 1;
    if (busy && (int'(mux_sel) != exp_ch)) mux_err <= mux_err + 1;
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int ch, input int n);
    @(negedge clk);
    chan_in = CH_W'(ch);
    target  = n;
    start   = 1'b1;
    set_cnt = 0; chg_cnt = 0; dis_cnt = 0; mux_err = 0;
    exp_ch  = ch;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(int'(mux_sel) == ch, "R2 mux_sel latched", int'(mux_sel), ch);
  endtask

  task automatic wait_done(input int ch, input int n);
    int k = 0;
    int er, eo;
    while (!done && k < LIM) begin
      if (k == 5) begin
        chan_in = CH_W'((ch + 7) % 16);   // R7: request while busy
        start   = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    er = (n <= MAXV) ? n : MAXV;
    eo = (n > MAXV) ? 1 : 0;
    chk(done == 1'b1, "R8 done seen", int'(done), 1);
    chk(int'(result) == er, "R5 result", int'(result), er);
    chk(int'(overflow) == eo, "R6 overflow", int'(overflow), eo);
    chk(int'(chan_tag) == ch, "R8 chan_tag", int'(chan_tag), ch);
    chk(set_cnt == SETTLE, "R2 settle length", set_cnt, SETTLE);
    chk(chg_cnt == WINDOW, "R3 charge length", chg_cnt, WINDOW);
    chk(dis_cnt == er + 1, "R5 discharge length", dis_cnt, er + 1);
    chk(mux_err == 0, "R7 mux_sel held", mux_err, 0);
    chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
  endtask

  task automatic run_conv(input int ch, input int n);
    int r0, t0, o0;
    do_start(ch, n);
    wait_done(ch, n);
    r0 = int'(result); t0 = int'(chan_tag); o0 = int'(overflow);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(int'(result) == r0 && int'(chan_tag) == t0 && int'(overflow) == o0,
        "R8 outputs hold", int'(result), r0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && charge_en == 0 && discharge_en == 0,
        "R1 reset flags", int'({busy, done, charge_en, discharge_en}), 0);
    chk(result == '0 && overflow == 0, "R1 reset result", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && result == '0, "R1 after reset", int'(busy), 0);

    // Sweep trip point across the full range and past saturation (R5, R6)
    for (int n = 0; n <= MAXV + 3; n++) run_conv(n % 16, n);

    // R9: new request issued in the done cycle
    do_start(3, 5);
    wait_done(3, 5);
    chan_in = 4'd9;
    target  = 20;
    start   = 1'b1;
    set_cnt = 0; chg_cnt = 0; dis_cnt = 0; mux_err = 0;
    exp_ch  = 9;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 start in done cycle accepted", int'(busy), 1);
    chk(int'(mux_sel) == 9, "R9 new channel", int'(mux_sel), 9);
    wait_done(9, 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule